// File: doc/BRIEF.md
# Console and Interrupt Port Peripheral

This block sits on the platform side of a small processor's I/O port bus. The bus carries a 9-bit port number, 16-bit write data with a write strobe that lasts exactly one clock, and a 16-bit read value. The peripheral has to return that read value combinationally in the same cycle, because the processor has no wait states. Behind the bus, the block offers five things:

- an end-of-program flag;
- a console input byte queue, filled by a host through a valid/ready byte interface;
- a console output byte queue, drained by a host through a valid/ready byte interface;
- an interrupt status word;
- an interrupt enable mask.

The interrupt request line to the processor is the OR of the interrupt sources that are both pending and enabled. There are two sources. Source 0 means the input queue holds a byte. Source 1 means the output queue has room. Reading never changes state. Software consumes an input byte by writing to the input port, and sends an output byte by writing to the output port.

Top module: `console_irq_hub`

## Requirements
- R1: After reset, the mask is all zeros, `irq` and `prog_done` are low, both queues are empty, `in_ready` is high and `out_valid` is low.
- R2: A read of port 2 returns 16'h8000 (bit 15 set, all other bits zero) when the input queue is empty. Otherwise it returns the oldest queued byte in bits 7:0 with bits 15:8 zero. The read does not remove the byte.
- R3: A write to port 2 discards the oldest input byte, whatever the data. Bytes are delivered in arrival order. A write to port 2 with an empty queue has no effect.
- R4: `in_ready` is low while the input queue holds `IN_DEPTH` bytes. A byte offered while `in_ready` is low is not stored.
- R5: A write to port 3 queues bits 7:0 of the write data. The host sees the queued bytes on `out_byte` with `out_valid`, in write order. Each byte leaves on a cycle where `out_valid` and `out_ready` are both high.
- R6: A read of port 3 returns 1 when the output queue has room and 0 when it holds `OUT_DEPTH` bytes. A port 3 write to a full queue is dropped.
- R7: A read of port 4 returns the status word. Bit 0 = (input queue not empty) AND mask bit 0. Bit 1 = (output queue not full) AND mask bit 1. Bits 15:2 are zero. Writes to port 4 have no effect.
- R8: A write to port 5 loads the mask from write-data bits 1:0. A read of port 5 returns the mask zero-extended to 16 bits.
- R9: `irq` is high exactly when the status word is non-zero.
- R10: A write to port 0 sets `prog_done` from the next cycle. It stays high until reset. A read of port 0 returns zero.
- R11: Reads of any port other than 2, 3, 4 and 5 return zero. Writes to ports other than 0, 2, 3 and 5 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 9 | Port number of the current access |
| io_wdata | input | 16 | Write data |
| io_wvalid | input | 1 | One-cycle write strobe |
| io_rdata | output | 16 | Combinational read value for `io_addr` |
| irq | output | 1 | Interrupt request to the processor |
| prog_done | output | 1 | Sticky end-of-program flag |
| in_byte | input | 8 | Host input byte |
| in_valid | input | 1 | Host offers `in_byte` |
| in_ready | output | 1 | Input queue can take a byte |
| out_byte | output | 8 | Oldest queued output byte |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Host takes `out_byte` |

## Verification
The queues are tested with interleaved sequences:
- two distinct bytes, then repeated reads, then discards, which separates a read that pops from a read that only peeks;
- a discard on an empty queue followed by a push, which shows whether an empty pop corrupts the pointers;
- fills past capacity, which expose whether an overflow byte was stored or a full write slipped in.

The status tests sweep the mask through 0, 3, 1 and 2 while both queues move between empty and full, which separates the enable gating from the raw pending state. Writes with all bits set, sent to reserved ports and to the status port, separate correct address decoding from aliasing onto the real registers.

// File: rtl/console_irq_pkg.sv
package console_irq_pkg;
  localparam int unsigned PORT_DONE   = 0;
  localparam int unsigned PORT_CIN    = 2;
  localparam int unsigned PORT_COUT   = 3;
  localparam int unsigned PORT_STATUS = 4;
  localparam int unsigned PORT_MASK   = 5;
  localparam int unsigned SRC_CIN     = 0;
  localparam int unsigned SRC_COUT    = 1;
  localparam int unsigned NUM_SRC     = 2;
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;
  logic             do_push, do_pop;

  assign full    = (fill == CAP);
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic [NSRC-1:0] pending,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign status[s] = pending[s] & mask[s];
  end

  assign irq = |status;
endmodule

// File: rtl/console_irq_hub.sv
module console_irq_hub
  import console_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IN_DEPTH  = 4,
  parameter int unsigned OUT_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wvalid,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq,
  output logic              prog_done,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam logic [ADDR_W-1:0] A_DONE   = ADDR_W'(PORT_DONE);
  localparam logic [ADDR_W-1:0] A_CIN    = ADDR_W'(PORT_CIN);
  localparam logic [ADDR_W-1:0] A_COUT   = ADDR_W'(PORT_COUT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(PORT_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(PORT_MASK);
  localparam logic [DATA_W-1:0] EMPTY_WORD = DATA_W'(1) << (DATA_W - 1);

  logic          wr_done, wr_cin, wr_cout, wr_mask;
  logic [7:0]    cin_head;
  logic          cin_full, cin_empty, cout_full, cout_empty;
  logic [NUM_SRC-1:0] pending, mask, status;
  logic          unused_wdata_hi;

  assign wr_done = io_wvalid && (io_addr == A_DONE);
  assign wr_cin  = io_wvalid && (io_addr == A_CIN);
  assign wr_cout = io_wvalid && (io_addr == A_COUT);
  assign wr_mask = io_wvalid && (io_addr == A_MASK);
  assign unused_wdata_hi = ^io_wdata[DATA_W-1:8];

  byte_queue #(.WIDTH(8), .DEPTH(IN_DEPTH)) u_cin (
    .clk(clk), .rst(rst),
    .push(in_valid), .push_data(in_byte),
    .pop(wr_cin), .head(cin_head),
    .full(cin_full), .empty(cin_empty)
  );

  byte_queue #(.WIDTH(8), .DEPTH(OUT_DEPTH)) u_cout (
    .clk(clk), .rst(rst),
    .push(wr_cout), .push_data(io_wdata[7:0]),
    .pop(out_ready), .head(out_byte),
    .full(cout_full), .empty(cout_empty)
  );

  assign in_ready  = !cin_full;
  assign out_valid = !cout_empty;

  assign pending[SRC_CIN]  = !cin_empty;
  assign pending[SRC_COUT] = !cout_full;

  irq_gate #(.NSRC(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(wr_mask), .mask_wdata(io_wdata[NUM_SRC-1:0]),
    .pending(pending), .mask(mask), .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)          prog_done <= 1'b0;
    else if (wr_done) prog_done <= 1'b1;
  end

  // combinational return: the bus has no wait states
  always_comb begin
    io_rdata = '0;
    case (io_addr)
      A_CIN:    io_rdata = cin_empty ? EMPTY_WORD : DATA_W'(cin_head);
      A_COUT:   io_rdata = DATA_W'(!cout_full);
      A_STATUS: io_rdata = DATA_W'(status);
      A_MASK:   io_rdata = DATA_W'(mask);
      default:  io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/console_irq_hub_chk.sv
module console_irq_hub_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wvalid,
  input logic [DATA_W-1:0] io_rdata,
  input logic              irq,
  input logic              prog_done,
  input logic [7:0]        out_byte,
  input logic              out_valid,
  input logic              out_ready
);
  a_r2_empty_word: assert property (@(posedge clk) disable iff (rst)
    (io_addr == ADDR_W'(2) && io_rdata[DATA_W-1]) |-> (io_rdata[DATA_W-2:0] == '0));
  a_r2_byte_only: assert property (@(posedge clk) disable iff (rst)
    (io_addr == ADDR_W'(2) && !io_rdata[DATA_W-1]) |-> (io_rdata[DATA_W-2:8] == '0));
  a_r6_space_flag: assert property (@(posedge clk) disable iff (rst)
    (io_addr == ADDR_W'(3)) |-> (io_rdata <= DATA_W'(1)));
  a_r7_status_width: assert property (@(posedge clk) disable iff (rst)
    (io_addr == ADDR_W'(4)) |-> (io_rdata[DATA_W-1:2] == '0));
  a_r9_irq_status: assert property (@(posedge clk) disable iff (rst)
    (io_addr == ADDR_W'(4)) |-> (irq == (io_rdata[1:0] != 2'b00)));
  a_r10_done_set: assert property (@(posedge clk) disable iff (rst)
    (io_wvalid && io_addr == ADDR_W'(0)) |=> prog_done);
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> prog_done);
  a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (io_addr >= ADDR_W'(6) || io_addr == ADDR_W'(1) || io_addr == ADDR_W'(0))
      |-> (io_rdata == '0));
endmodule

bind console_irq_hub console_irq_hub_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wvalid(io_wvalid),
  .io_rdata(io_rdata), .irq(irq), .prog_done(prog_done),
  .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/console_irq_hub_tb_top.sv
module console_irq_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  io_addr = 9'd40;
  logic [15:0] io_wdata = '0;
  logic        io_wvalid = 1'b0;
  logic [15:0] io_rdata;
  logic        irq, prog_done;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  console_irq_hub dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wvalid(io_wvalid), .io_rdata(io_rdata), .irq(irq),
    .prog_done(prog_done), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .out_byte(out_byte), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wvalid = 1'b1;
    @(negedge clk);
    io_wvalid = 1'b0; io_addr = 9'd40;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic push_in(input logic [7:0] b);
    @(negedge clk);
    in_byte = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_out(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {15'd0, out_valid}, 16'd1);
    check(req, {8'd0, out_byte}, {8'd0, exp});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(9'd2, v); check("R1 input empty", v, 16'h8000);
    rd(9'd3, v); check("R1 output room", v, 16'h0001);
    rd(9'd5, v); check("R1 mask", v, 16'h0000);
    rd(9'd4, v); check("R1 status", v, 16'h0000);
    check("R1 irq/done/ready/valid", {12'd0, irq, prog_done, in_ready, out_valid}, 16'h0002);
  endtask

  task automatic t_cin_order();
    logic [15:0] v;
    push_in(8'hA5); push_in(8'h3C);
    rd(9'd2, v); check("R2 head byte", v, 16'h00A5);
    rd(9'd2, v); check("R2 read does not pop", v, 16'h00A5);
    wr(9'd2, 16'hFFFF);
    rd(9'd2, v); check("R3 next byte", v, 16'h003C);
    wr(9'd2, 16'h0000);
    rd(9'd2, v); check("R2 empty flag", v, 16'h8000);
    wr(9'd2, 16'h0000);
    push_in(8'h77);
    rd(9'd2, v); check("R3 empty discard harmless", v, 16'h0077);
    wr(9'd2, 16'h0000);
    rd(9'd2, v); check("R3 drained", v, 16'h8000);
  endtask

  task automatic t_cin_full();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) push_in(8'h10 + 8'(i));
    @(negedge clk);
    check("R4 in_ready low when full", {15'd0, in_ready}, 16'd0);
    push_in(8'h99);
    for (int i = 0; i < 4; i++) begin
      rd(9'd2, v); check("R4 stored order", v, 16'h0010 + 16'(i));
      wr(9'd2, 16'h0000);
    end
    rd(9'd2, v); check("R4 overflow byte not stored", v, 16'h8000);
  endtask

  task automatic t_cout();
    wr(9'd3, 16'h1241);
    wr(9'd3, 16'hFF42);
    pop_out("R5 first byte", 8'h41);
    pop_out("R5 second byte", 8'h42);
    @(negedge clk);
    check("R5 queue drained", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_cout_full();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) wr(9'd3, 16'h0060 + 16'(i));
    rd(9'd3, v); check("R6 no room", v, 16'h0000);
    wr(9'd3, 16'h00EE);
    for (int i = 0; i < 4; i++) pop_out("R6 kept bytes", 8'h60 + 8'(i));
    @(negedge clk);
    check("R6 full write dropped", {15'd0, out_valid}, 16'd0);
    rd(9'd3, v); check("R6 room again", v, 16'h0001);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(9'd5, 16'hFFFF);
    rd(9'd5, v); check("R8 mask readback", v, 16'h0003);
    rd(9'd4, v); check("R7 output ready only", v, 16'h0002);
    check("R9 irq high", {15'd0, irq}, 16'd1);
    push_in(8'h55);
    rd(9'd4, v); check("R7 both pending", v, 16'h0003);
    wr(9'd5, 16'h0001);
    rd(9'd4, v); check("R7 mask gates output", v, 16'h0001);
    wr(9'd4, 16'hFFFF);
    rd(9'd5, v); check("R7 status write ignored", v, 16'h0001);
    wr(9'd2, 16'h0000);
    rd(9'd4, v); check("R7 input gone", v, 16'h0000);
    check("R9 irq low", {15'd0, irq}, 16'd0);
    wr(9'd5, 16'h0002);
    for (int i = 0; i < 4; i++) wr(9'd3, 16'h0070 + 16'(i));
    rd(9'd4, v); check("R7 full output not ready", v, 16'h0000);
    check("R9 irq low when full", {15'd0, irq}, 16'd0);
    pop_out("R5 drain", 8'h70);
    rd(9'd4, v); check("R7 room returns", v, 16'h0002);
    check("R9 irq follows", {15'd0, irq}, 16'd1);
    for (int i = 1; i < 4; i++) pop_out("R5 drain", 8'h70 + 8'(i));
    wr(9'd5, 16'h0000);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr(9'd6, 16'hFFFF); wr(9'd1, 16'hFFFF); wr(9'd40, 16'hFFFF); wr(9'd300, 16'hFFFF);
    rd(9'd5, v); check("R11 mask untouched", v, 16'h0000);
    rd(9'd2, v); check("R11 input untouched", v, 16'h8000);
    check("R11 no output/done", {14'd0, out_valid, prog_done}, 16'd0);
    rd(9'd0, v); check("R10 port 0 reads zero", v, 16'h0000);
    rd(9'd1, v); check("R11 port 1 zero", v, 16'h0000);
    rd(9'd6, v); check("R11 port 6 zero", v, 16'h0000);
    rd(9'd31, v); check("R11 port 31 zero", v, 16'h0000);
    rd(9'd300, v); check("R11 port 300 zero", v, 16'h0000);
  endtask

  task automatic t_done();
    wr(9'd0, 16'h0000);
    check("R10 done set", {15'd0, prog_done}, 16'd1);
    repeat (5) @(negedge clk);
    check("R10 done sticky", {15'd0, prog_done}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cin_order();
    t_cin_full();
    t_cout();
    t_cout_full();
    t_status();
    t_reserved();
    t_done();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule